// File: doc/BRIEF.md
# System-management-mode save and resume sequencer

This block runs the entry and exit sequences of system management mode for a 32-bit core. When the core raises an SMI request and is not already in that mode, the sequencer writes the architectural state, one 32-bit word at a time, to a save area. The save area starts at SMBASE + 0x8000, and the words sit at sparse fixed offsets. It then hands the core a forced entry state and raises `smm_active`. When the core raises a resume request while in the mode, the sequencer reads the same words back and converts them into the state to reload. It moves SMBASE only if the saved revision word allows it, then drops `smm_active`.

The core supplies its state as 51 words on `arch_in` and takes new state from `arch_out` in the cycle where `arch_load` is high. Memory is reached through a single-outstanding valid/ready master port. `arch_in` must stay stable while a sequence runs.

Top module: `smm_sequencer`

## Requirements
- R1: While reset is high, and after it is released, `smm_active`, `done`, `arch_load` and `mem_valid` are 0 and `smbase` equals the parameter SMBASE_RESET (default 0x00030000).
- R2: An SMI request with `smm_active` low starts a save of 53 word writes (`mem_write`=1) in slot order 0 to 52. Each write goes to address smbase + 0x8000 + offset. Slot k below 51 carries word k of `arch_in`. The slots and their offsets are as follows. Slots 0 to 13 hold CR0, CR3, EFLAGS, EIP, EDI, ESI, EBP, ESP, EBX, EDX, ECX, EAX, DR6 and DR7, at 0x7FFC - 4k. Slots 14 to 17 hold the task register selector, base, limit and attributes, at 0x7FC4, 0x7F64, 0x7F60 and 0x7F5C. Slots 18 to 21 hold the local table selector, base, limit and attributes, at 0x7FC0, 0x7F80, 0x7F7C and 0x7F78. Slots 22 to 25 hold the global table base and limit and the interrupt table base and limit, at 0x7F74, 0x7F70, 0x7F58 and 0x7F54. For segment g (0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS), slots 26+4g to 29+4g hold the selector at 0x7FA8+4g, then base at D+8, limit at D+4 and attributes at D, where D is 0x7F84+12g for g<3 and 0x7F2C+12(g-3) otherwise. Slot 50 holds CR4 at 0x7F14, slot 51 the revision word at 0x7EFC, and slot 52 SMBASE at 0x7EF8.
- R3: Save data transforms: selector slots are written as the low 16 bits zero-extended. Attribute slots are written as (value >> 8) & 0xF0FF. The revision slot carries the parameter REVISION (default 0x00020000), and the SMBASE slot carries the current `smbase`.
- R4: Only one access is outstanding at a time. An access completes on a clock edge where `mem_valid` and `mem_ready` are both high. Until then, address, write flag and write data stay unchanged.
- R5: The entry state on `arch_out` is `arch_in` with these changes. EIP becomes 0x8000. CR0 loses bits 0, 2, 3 and 31. EFLAGS keeps only the bits in 0x0CD5. CR4 becomes 0 and DR7 becomes 0x400. Every segment gets limit 0xFFFFFFFF and attributes 0. CS gets selector smbase[19:4] and base smbase. The other five segments get selector 0 and base 0.
- R6: One cycle after the final save write completes, `arch_load` and `done` are high for exactly one cycle, and `smm_active` becomes 1 in that same cycle.
- R7: A resume request with `smm_active` high starts reads (`mem_write`=0) of slots 0 to 51, at the same addresses as in R2. CR4 therefore comes after all segment slots. Slot 52 is read only when the revision word read has bit 17 set.
- R8: Restore transforms into `arch_out`: selector slots take the low 16 bits. Attribute slots take (word & 0xF0FF) << 8. EFLAGS becomes (arch_in EFLAGS & 0x0CD5) | (word & ~0x0CD5). All other slots take the word unchanged.
- R9: When slot 52 is read, `smbase` becomes the word with bits 14:0 cleared. Otherwise `smbase` is unchanged.
- R10: One cycle after the last restore read completes, `arch_load` and `done` pulse for one cycle, and `smm_active` returns to 0 in that cycle.
- R11: A resume request while `smm_active` is low, or an SMI request while it is high, causes no memory access, no `done` pulse and no change of `smm_active` or `smbase`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req | input | 1 | Request to enter the mode |
| rsm_req | input | 1 | Request to resume from the mode |
| arch_in | input | 51x32 | Current architectural state, word k as in R2 |
| arch_out | output | 51x32 | State for the core to load, same word order |
| arch_load | output | 1 | One-cycle strobe: `arch_out` is to be loaded |
| smm_active | output | 1 | High while in the mode |
| done | output | 1 | One-cycle pulse at the end of each sequence |
| smbase | output | 32 | Current save-area base register |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data, sampled with `mem_ready` |

## Verification
The first access appears in the cycle after the request edge. Each later access appears in the cycle after the previous valid-and-ready edge. `done`, `arch_load` and the change of `smm_active` and `smbase` come one cycle after the last completing edge. The bench stalls `mem_ready` with a pseudo-random pattern, so sequence lengths vary. It therefore never counts cycles. A scoreboard compares every completed access, in order, at the falling edge before the edge that completes it. Final state is checked at the falling edge where `done` is seen, and pulse widths at the next falling edge.

// File: rtl/smm_pkg.sv
package smm_pkg;

    localparam int NUM_SEGS  = 6;
    localparam int NUM_ARCH  = 51;
    localparam int SLOT_REV  = NUM_ARCH;
    localparam int SLOT_BASE = NUM_ARCH + 1;
    localparam int NUM_SLOTS = NUM_ARCH + 2;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    // word indices into the architectural vector
    localparam int IX_CR0  = 0;
    localparam int IX_EFL  = 2;
    localparam int IX_EIP  = 3;
    localparam int IX_DR7  = 13;
    localparam int IX_TR   = 14;
    localparam int IX_LDT  = 18;
    localparam int IX_TBL  = 22;
    localparam int IX_SEG0 = 26;
    localparam int IX_CR4  = IX_SEG0 + 4 * NUM_SEGS;
    localparam int CS_NUM  = 1;

    // field position inside a four-word descriptor group
    localparam int F_SEL  = 0;
    localparam int F_BASE = 1;
    localparam int F_LIM  = 2;
    localparam int F_FLG  = 3;

    typedef logic [31:0]       word_t;
    typedef logic [SLOT_W-1:0] slot_t;

    typedef enum logic [1:0] {KIND_PLAIN, KIND_SEL, KIND_FLG} slot_kind_e;
    typedef enum logic [1:0] {SEQ_IDLE, SEQ_SAVE, SEQ_LOAD}   seq_state_e;

    localparam word_t AREA_BIAS  = 32'h0000_8000;
    localparam word_t ATTR_MASK  = 32'h0000_F0FF;
    localparam word_t EFL_KEEP   = 32'h0000_0CD5;
    localparam word_t CR0_DROP   = 32'h8000_000D;
    localparam word_t ENTRY_EIP  = 32'h0000_8000;
    localparam word_t ENTRY_DR7  = 32'h0000_0400;
    localparam word_t RELOC_BIT  = 32'h0002_0000;
    localparam word_t BASE_ALIGN = 32'hFFFF_8000;

    function automatic logic [15:0] slot_offset(input slot_t s);
        int k, g, f, grp, off;
        k   = int'(s);
        off = 0;
        if (k < IX_TR) begin
            off = 'h7FFC - 4 * k;
        end else if (k < IX_LDT) begin
            case (k - IX_TR)
                F_SEL:   off = 'h7FC4;
                F_BASE:  off = 'h7F64;
                F_LIM:   off = 'h7F60;
                default: off = 'h7F5C;
            endcase
        end else if (k < IX_TBL) begin
            case (k - IX_LDT)
                F_SEL:   off = 'h7FC0;
                F_BASE:  off = 'h7F80;
                F_LIM:   off = 'h7F7C;
                default: off = 'h7F78;
            endcase
        end else if (k < IX_SEG0) begin
            case (k - IX_TBL)
                0:       off = 'h7F74;
                1:       off = 'h7F70;
                2:       off = 'h7F58;
                default: off = 'h7F54;
            endcase
        end else if (k < IX_CR4) begin
            g   = (k - IX_SEG0) / 4;
            f   = (k - IX_SEG0) % 4;
            grp = (g < 3) ? ('h7F84 + 12 * g) : ('h7F2C + 12 * (g - 3));
            case (f)
                F_SEL:   off = 'h7FA8 + 4 * g;
                F_BASE:  off = grp + 8;
                F_LIM:   off = grp + 4;
                default: off = grp;
            endcase
        end else if (k == IX_CR4) begin
            off = 'h7F14;
        end else if (k == SLOT_REV) begin
            off = 'h7EFC;
        end else begin
            off = 'h7EF8;
        end
        return 16'(off);
    endfunction

    function automatic slot_kind_e slot_kind(input slot_t s);
        int k;
        k = int'(s);
        if (k == IX_TR + F_SEL || k == IX_LDT + F_SEL) return KIND_SEL;
        if (k == IX_TR + F_FLG || k == IX_LDT + F_FLG) return KIND_FLG;
        if (k >= IX_SEG0 && k < IX_CR4) begin
            if ((k - IX_SEG0) % 4 == F_SEL) return KIND_SEL;
            if ((k - IX_SEG0) % 4 == F_FLG) return KIND_FLG;
        end
        return KIND_PLAIN;
    endfunction

    function automatic word_t pack_word(input slot_kind_e kd, input word_t v);
        case (kd)
            KIND_SEL: return {16'h0000, v[15:0]};
            KIND_FLG: return (v >> 8) & ATTR_MASK;
            default:  return v;
        endcase
    endfunction

    function automatic word_t unpack_word(input slot_kind_e kd, input word_t w);
        case (kd)
            KIND_SEL: return {16'h0000, w[15:0]};
            KIND_FLG: return (w & ATTR_MASK) << 8;
            default:  return w;
        endcase
    endfunction

endpackage

// File: rtl/smm_addr_gen.sv
module smm_addr_gen
    import smm_pkg::*;
(
    input  word_t      base,
    input  slot_t      slot,
    output word_t      addr,
    output slot_kind_e kind
);
    always_comb begin
        addr = base + AREA_BIAS + {16'h0000, slot_offset(slot)};
        kind = slot_kind(slot);
    end
endmodule

// File: rtl/smm_entry_state.sv
module smm_entry_state
    import smm_pkg::*;
(
    input  word_t [NUM_ARCH-1:0] cur,
    input  word_t                base,
    output word_t [NUM_ARCH-1:0] nxt
);
    always_comb begin
        nxt          = cur;
        nxt[IX_EIP]  = ENTRY_EIP;
        nxt[IX_CR0]  = cur[IX_CR0] & ~CR0_DROP;
        nxt[IX_EFL]  = cur[IX_EFL] & EFL_KEEP;
        nxt[IX_CR4]  = '0;
        nxt[IX_DR7]  = ENTRY_DR7;
        for (int g = 0; g < NUM_SEGS; g++) begin
            nxt[IX_SEG0 + 4*g + F_SEL]  = (g == CS_NUM) ? {16'h0000, base[19:4]} : '0;
            nxt[IX_SEG0 + 4*g + F_BASE] = (g == CS_NUM) ? base : '0;
            nxt[IX_SEG0 + 4*g + F_LIM]  = '1;
            nxt[IX_SEG0 + 4*g + F_FLG]  = '0;
        end
    end
endmodule

// File: rtl/smm_restore_xform.sv
module smm_restore_xform
    import smm_pkg::*;
(
    input  slot_t slot,
    input  word_t rdata,
    input  word_t cur_efl,
    output word_t word
);
    always_comb begin
        if (int'(slot) == IX_EFL)
            word = (cur_efl & EFL_KEEP) | (rdata & ~EFL_KEEP);
        else
            word = unpack_word(slot_kind(slot), rdata);
    end
endmodule

// File: rtl/smm_sequencer.sv
module smm_sequencer
    import smm_pkg::*;
#(
    parameter logic [31:0] SMBASE_RESET = 32'h0003_0000,
    parameter logic [31:0] REVISION     = 32'h0002_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smi_req,
    input  logic                      rsm_req,
    input  logic [NUM_ARCH-1:0][31:0] arch_in,
    output logic [NUM_ARCH-1:0][31:0] arch_out,
    output logic                      arch_load,
    output logic                      smm_active,
    output logic                      done,
    output logic [31:0]               smbase,
    output logic                      mem_valid,
    output logic                      mem_write,
    output logic [31:0]               mem_addr,
    output logic [31:0]               mem_wdata,
    input  logic                      mem_ready,
    input  logic [31:0]               mem_rdata
);
    localparam slot_t LAST_SLOT = slot_t'(SLOT_BASE);
    localparam slot_t REV_SLOT  = slot_t'(SLOT_REV);
    localparam slot_t ARCH_END  = slot_t'(NUM_ARCH);

    seq_state_e            state_q;
    slot_t                 slot_q;
    word_t                 base_q;
    logic                  active_q, done_q, load_q;
    word_t [NUM_ARCH-1:0]  arch_q;

    slot_t                 arch_idx;
    slot_kind_e            kind;
    word_t                 restored;
    word_t [NUM_ARCH-1:0]  entry_vec;
    logic                  fire, reloc, load_end;

    smm_addr_gen u_addr (
        .base (base_q),
        .slot (slot_q),
        .addr (mem_addr),
        .kind (kind)
    );

    smm_entry_state u_entry (
        .cur  (arch_in),
        .base (base_q),
        .nxt  (entry_vec)
    );

    smm_restore_xform u_xform (
        .slot    (slot_q),
        .rdata   (mem_rdata),
        .cur_efl (arch_in[IX_EFL]),
        .word    (restored)
    );

    always_comb begin
        arch_idx  = (slot_q < ARCH_END) ? slot_q : '0;
        mem_valid = (state_q != SEQ_IDLE);
        mem_write = (state_q == SEQ_SAVE);
        fire      = mem_valid && mem_ready;
        reloc     = (mem_rdata & RELOC_BIT) != '0;
        load_end  = (slot_q == LAST_SLOT) || ((slot_q == REV_SLOT) && !reloc);
        if (slot_q == REV_SLOT)
            mem_wdata = REVISION;
        else if (slot_q == LAST_SLOT)
            mem_wdata = base_q;
        else
            mem_wdata = pack_word(kind, arch_in[arch_idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SEQ_IDLE;
            slot_q   <= '0;
            base_q   <= SMBASE_RESET;
            active_q <= 1'b0;
            done_q   <= 1'b0;
            load_q   <= 1'b0;
            arch_q   <= '0;
        end else begin
            done_q <= 1'b0;
            load_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    slot_q <= '0;
                    if (!active_q && smi_req)
                        state_q <= SEQ_SAVE;
                    else if (active_q && rsm_req)
                        state_q <= SEQ_LOAD;
                end
                SEQ_SAVE: begin
                    if (fire) begin
                        if (slot_q == LAST_SLOT) begin
                            state_q  <= SEQ_IDLE;
                            arch_q   <= entry_vec;
                            load_q   <= 1'b1;
                            done_q   <= 1'b1;
                            active_q <= 1'b1;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                SEQ_LOAD: begin
                    if (fire) begin
                        if (slot_q < ARCH_END)
                            arch_q[arch_idx] <= restored;
                        if (slot_q == LAST_SLOT)
                            base_q <= mem_rdata & BASE_ALIGN;
                        if (slot_q >= ARCH_END && load_end) begin
                            state_q  <= SEQ_IDLE;
                            load_q   <= 1'b1;
                            done_q   <= 1'b1;
                            active_q <= 1'b0;
                        end else begin
                            slot_q <= slot_q + 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign arch_out   = arch_q;
    assign arch_load  = load_q;
    assign smm_active = active_q;
    assign done       = done_q;
    assign smbase     = base_q;

endmodule

// File: rtl/smm_sequencer_chk.sv
module smm_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic        smi_req,
    input logic        rsm_req,
    input logic        smm_active,
    input logic        done,
    input logic        arch_load,
    input logic        mem_valid,
    input logic        mem_ready,
    input logic        mem_write,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] smbase
);
    a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_wdata) && $stable(mem_write));

    a_r6_entry_marks: assert property (@(posedge clk) disable iff (rst)
        $rose(smm_active) |-> done && arch_load);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !arch_load);

    a_r10_exit_marks: assert property (@(posedge clk) disable iff (rst)
        $fell(smm_active) |-> done && arch_load);

    a_r2_writes_outside: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_write |-> !smm_active);

    a_r7_reads_inside: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_write |-> smm_active);

    a_r11_smi_ignored: assert property (@(posedge clk) disable iff (rst)
        smm_active && !mem_valid && smi_req && !rsm_req |=> !mem_valid);

    a_r11_rsm_ignored: assert property (@(posedge clk) disable iff (rst)
        !smm_active && !mem_valid && rsm_req && !smi_req |=> !mem_valid);

    a_r9_base_moves_on_exit: assert property (@(posedge clk) disable iff (rst)
        !$stable(smbase) |-> done && !smm_active && (smbase[14:0] == 15'h0));
endmodule

bind smm_sequencer smm_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .smi_req    (smi_req),
    .rsm_req    (rsm_req),
    .smm_active (smm_active),
    .done       (done),
    .arch_load  (arch_load),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .smbase     (smbase)
);

// File: tb/smm_sequencer_tb.sv
`timescale 1ns/1ps
module smm_sequencer_tb;
    localparam int NA = 51;
    localparam int NS = 53;

    logic                clk = 1'b0;
    logic                rst;
    logic                smi_req, rsm_req;
    logic [NA-1:0][31:0] arch_in;
    logic [NA-1:0][31:0] arch_out;
    logic                arch_load, smm_active, done;
    logic [31:0]         smbase;
    logic                mem_valid, mem_write, mem_ready;
    logic [31:0]         mem_addr, mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    smm_sequencer u_dut (
        .clk(clk), .rst(rst), .smi_req(smi_req), .rsm_req(rsm_req),
        .arch_in(arch_in), .arch_out(arch_out), .arch_load(arch_load),
        .smm_active(smm_active), .done(done), .smbase(smbase),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    typedef struct { bit wr; logic [31:0] addr; logic [31:0] data; } acc_t;
    acc_t                exp_q[$];
    logic [31:0]         mem [logic [31:0]];
    int                  off_t [NS];
    int                  kind_t [NS];   // 0 plain, 1 selector, 2 attributes
    int                  checks = 0, errors = 0;
    logic [31:0]         model_base;
    logic [7:0]          lfsr = 8'h5A;
    bit                  p_valid = 0, p_ready = 0, p_wr = 0;
    logic [31:0]         p_addr = '0, p_wdata = '0;
    logic [NA-1:0][31:0] ev;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic void build_map();
        for (int k = 0; k < 14; k++) begin off_t[k] = 'h7FFC - 4*k; kind_t[k] = 0; end
        off_t[14] = 'h7FC4; off_t[15] = 'h7F64; off_t[16] = 'h7F60; off_t[17] = 'h7F5C;
        off_t[18] = 'h7FC0; off_t[19] = 'h7F80; off_t[20] = 'h7F7C; off_t[21] = 'h7F78;
        off_t[22] = 'h7F74; off_t[23] = 'h7F70; off_t[24] = 'h7F58; off_t[25] = 'h7F54;
        for (int k = 14; k < 26; k++) kind_t[k] = 0;
        kind_t[14] = 1; kind_t[17] = 2; kind_t[18] = 1; kind_t[21] = 2;
        for (int g = 0; g < 6; g++) begin
            int b, d;
            b = 26 + 4*g;
            d = (g < 3) ? ('h7F84 + 12*g) : ('h7F2C + 12*(g-3));
            off_t[b] = 'h7FA8 + 4*g; kind_t[b] = 1;
            off_t[b+1] = d + 8;      kind_t[b+1] = 0;
            off_t[b+2] = d + 4;      kind_t[b+2] = 0;
            off_t[b+3] = d;          kind_t[b+3] = 2;
        end
        off_t[50] = 'h7F14; off_t[51] = 'h7EFC; off_t[52] = 'h7EF8;
        kind_t[50] = 0; kind_t[51] = 0; kind_t[52] = 0;
    endfunction

    function automatic logic [31:0] slot_addr(input logic [31:0] base, input int k);
        return base + 32'h8000 + 32'(off_t[k]);
    endfunction

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        acc_t e;
        if (!rst && p_valid && !p_ready)
            chk(mem_valid && mem_addr == p_addr && mem_wdata == p_wdata && mem_write == p_wr,
                "R4", "stalled access changed", mem_addr, p_addr);
        lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready = lfsr[0] | lfsr[2];
        if (!rst && mem_valid && mem_ready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R11", "unexpected access", mem_addr, 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk(mem_write == e.wr && mem_addr == e.addr, e.wr ? "R2" : "R7",
                    "access address", mem_addr, e.addr);
                if (e.wr) chk(mem_wdata == e.data, "R3", "save data", mem_wdata, e.data);
            end
            if (mem_write) mem[mem_addr] = mem_wdata;
            else           mem_rdata = rd_mem(mem_addr);
        end
        p_valid = mem_valid; p_ready = mem_ready; p_wr = mem_write;
        p_addr  = mem_addr;  p_wdata = mem_wdata;
    end

    task automatic set_pattern(input logic [31:0] seed);
        for (int k = 0; k < NA; k++)
            arch_in[k] = 32'hC3A5_0000 ^ (32'(k) * 32'h0101_0203) ^ seed;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 4000) begin @(negedge clk); n++; end
        chk(done, req, "done pulse seen", {31'h0, done}, 32'h1);
    endtask

    task automatic run_save();
        for (int k = 0; k < NS; k++) begin
            acc_t a;
            logic [31:0] v;
            a.wr = 1; a.addr = slot_addr(model_base, k);
            if (k == 51) v = 32'h0002_0000;
            else if (k == 52) v = model_base;
            else if (kind_t[k] == 1) v = {16'h0, arch_in[k][15:0]};
            else if (kind_t[k] == 2) v = (arch_in[k] >> 8) & 32'h0000_F0FF;
            else v = arch_in[k];
            a.data = v;
            exp_q.push_back(a);
        end
        ev = arch_in;
        ev[3] = 32'h8000; ev[0] = arch_in[0] & ~32'h8000_000D;
        ev[2] = arch_in[2] & 32'h0CD5; ev[50] = 0; ev[13] = 32'h400;
        for (int g = 0; g < 6; g++) begin
            ev[26+4*g]   = (g == 1) ? {16'h0, model_base[19:4]} : 32'h0;
            ev[26+4*g+1] = (g == 1) ? model_base : 32'h0;
            ev[26+4*g+2] = 32'hFFFF_FFFF;
            ev[26+4*g+3] = 32'h0;
        end
        smi_req = 1'b1; @(negedge clk); smi_req = 1'b0;
        wait_done("R6");
        chk(arch_load && smm_active, "R6", "load/active with done",
            {30'h0, arch_load, smm_active}, 32'h3);
        chk(exp_q.size() == 0, "R2", "all save writes done", 32'(exp_q.size()), 32'h0);
        for (int k = 0; k < NA; k++)
            chk(arch_out[k] == ev[k], "R5", $sformatf("entry word %0d", k), arch_out[k], ev[k]);
        @(negedge clk);
        chk(!done && !arch_load && smm_active, "R6", "single-cycle pulse",
            {29'h0, done, arch_load, smm_active}, 32'h1);
    endtask

    task automatic run_restore();
        logic [31:0] rev, nbase;
        rev   = rd_mem(slot_addr(model_base, 51));
        nbase = rev[17] ? (rd_mem(slot_addr(model_base, 52)) & 32'hFFFF_8000) : model_base;
        for (int k = 0; k < NS; k++) begin
            acc_t a;
            if (k == 52 && !rev[17]) break;
            a.wr = 0; a.addr = slot_addr(model_base, k); a.data = 0;
            exp_q.push_back(a);
        end
        for (int k = 0; k < NA; k++) begin
            logic [31:0] w;
            w = rd_mem(slot_addr(model_base, k));
            if (k == 2) ev[k] = (arch_in[2] & 32'h0CD5) | (w & ~32'h0CD5);
            else if (kind_t[k] == 1) ev[k] = {16'h0, w[15:0]};
            else if (kind_t[k] == 2) ev[k] = (w & 32'h0000_F0FF) << 8;
            else ev[k] = w;
        end
        rsm_req = 1'b1; @(negedge clk); rsm_req = 1'b0;
        wait_done("R10");
        chk(arch_load && !smm_active, "R10", "load with active low",
            {30'h0, arch_load, smm_active}, 32'h2);
        chk(exp_q.size() == 0, "R7", "all restore reads done", 32'(exp_q.size()), 32'h0);
        for (int k = 0; k < NA; k++)
            chk(arch_out[k] == ev[k], "R8", $sformatf("restored word %0d", k), arch_out[k], ev[k]);
        chk(smbase == nbase, "R9", "smbase after resume", smbase, nbase);
        model_base = nbase;
        @(negedge clk);
        chk(!done && !arch_load, "R10", "single-cycle pulse", {30'h0, done, arch_load}, 32'h0);
    endtask

    task automatic idle_ignore(input bit use_smi);
        logic act0;
        act0 = smm_active;
        if (use_smi) smi_req = 1'b1; else rsm_req = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            chk(!mem_valid && !done, "R11", "ignored request", {30'h0, mem_valid, done}, 32'h0);
        end
        smi_req = 1'b0; rsm_req = 1'b0;
        repeat (2) @(negedge clk);
        chk(smm_active == act0 && smbase == model_base, "R11", "state unchanged", smbase, model_base);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog requirement=all actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        build_map();
        rst = 1'b1; smi_req = 1'b0; rsm_req = 1'b0; mem_rdata = '0; mem_ready = 1'b0;
        model_base = 32'h0003_0000;
        set_pattern(32'h1357_9BDF);
        repeat (3) @(negedge clk);
        chk(!smm_active && !done && !arch_load && !mem_valid, "R1", "outputs in reset",
            {28'h0, smm_active, done, arch_load, mem_valid}, 32'h0);
        chk(smbase == 32'h0003_0000, "R1", "smbase in reset", smbase, 32'h0003_0000);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!smm_active && !mem_valid, "R1", "idle after reset", {30'h0, smm_active, mem_valid}, 32'h0);

        idle_ignore(1'b0);               // R11: resume while not active
        run_save();                      // R2 R3 R5 R6
        idle_ignore(1'b1);               // R11: SMI while active

        // alter the save area: relocation, selector high bits, attributes, flags
        mem[slot_addr(model_base, 52)] = 32'h000A_9234;
        mem[slot_addr(model_base, 2)]  = 32'hFFFF_FFFF;
        mem[slot_addr(model_base, 30)] = 32'hDEAD_BEEF;
        mem[slot_addr(model_base, 41)] = 32'hFFFF_FFFF;
        run_restore();                   // R7 R8 R9 R10
        chk(smbase == 32'h000A_8000, "R9", "relocated base value", smbase, 32'h000A_8000);

        set_pattern(32'h8642_0ACE);
        run_save();                      // second entry at relocated base
        mem[slot_addr(model_base, 51)] = 32'h0000_0064;
        mem[slot_addr(model_base, 52)] = 32'h0001_0000;
        run_restore();                   // R9: bit 17 clear, no relocation
        chk(smbase == 32'h000A_8000, "R9", "base kept without bit 17", smbase, 32'h000A_8000);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule